// File: doc/BRIEF.md
# Bit-Manipulation Logic Unit

This unit performs the everyday bit-level operations of a 32-bit integer datapath in one clocked stage. Given two operands and a 5-bit operation code, it computes one of: logic with an inverted second operand, inverted exclusive-or, leading- and trailing-zero counts, population count, signed or unsigned minimum and maximum, byte and halfword sign or zero extension, left and right rotation, a per-byte OR reduction, byte-order reversal, and single-bit clear, set, toggle and read.

The result is captured in a register together with a valid flag. An issue stage presents operands, opcode and `valid_in` in one cycle, and the result appears with `valid_out` on the following cycle. Decode, the register file and carry-less multiplication belong to other blocks.

Top module: `bml_unit`

## Requirements
- R1: `valid_out` equals the `valid_in` of the previous clock edge. After reset, `valid_out` and `result` are zero.
- R2: Logic ops: opcode 0 gives a AND NOT b, opcode 1 gives a OR NOT b, and opcode 2 gives NOT (a XOR b).
- R3: Opcode 3 counts leading zeros and opcode 4 counts trailing zeros. Both give 32 for a zero operand.
- R4: Opcode 5 gives the number of set bits in a (0 to 32).
- R5: Opcode 6 gives the signed min, 7 the signed max, 8 the unsigned min and 9 the unsigned max, all in two's complement.
- R6: Extension: opcode 10 sign-extends byte 0, 11 sign-extends halfword 0, 12 zero-extends byte 0, and 13 zero-extends halfword 0.
- R7: Opcode 14 rotates a left and 15 rotates it right, by b[4:0] bit positions. An amount of zero returns a unchanged, and b[31:5] is ignored.
- R8: Opcode 16 (OR-combine) sets each output byte to 0xFF if any bit of the same input byte is 1, and to 0x00 otherwise.
- R9: Opcode 17 reverses byte order: input byte 0 goes to bits 31:24, byte 1 to 23:16, byte 2 to 15:8 and byte 3 to 7:0.
- R10: Single-bit ops take the index from b[4:0]. Opcode 18 clears that bit, 19 sets it, and 20 inverts it. Opcode 21 returns the bit in result[0] with result[31:1] zero.
- R11: Opcodes 22 to 31 produce a result of zero.
- R12: The result register loads on every clock edge, whatever the state of `valid_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and opcode are valid |
| op_in | input | 5 | Operation code |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand or index |
| valid_out | output | 1 | Result is valid |
| result | output | 32 | Registered result |

## Verification
The assertions check on every cycle that the valid flag follows its input by one cycle and that an unused opcode leaves zero. They also check, from the registered inputs, that a zero amount passes a rotate through unchanged and that a bit read clears the upper bits. The specific arithmetic values need the bench's scenarios. These include the zero-operand counts of 32, signed against unsigned ordering across the sign boundary, rotation wrap-around, per-byte OR-combine patterns and byte order, which a scoreboard compares against values computed independently.

// File: rtl/bml_pkg.sv
package bml_pkg;

    localparam int DW = 32;
    localparam int OPW = 5;
    localparam int SHW = $clog2(DW);
    localparam int NBYTE = DW / 8;
    localparam int CNTW = SHW + 1;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ANDINV = 5'd0,
        OP_ORINV  = 5'd1,
        OP_XNOR   = 5'd2,
        OP_LZC    = 5'd3,
        OP_TZC    = 5'd4,
        OP_POP    = 5'd5,
        OP_MINS   = 5'd6,
        OP_MAXS   = 5'd7,
        OP_MINU   = 5'd8,
        OP_MAXU   = 5'd9,
        OP_SXB    = 5'd10,
        OP_SXH    = 5'd11,
        OP_ZXB    = 5'd12,
        OP_ZXH    = 5'd13,
        OP_ROTL   = 5'd14,
        OP_ROTR   = 5'd15,
        OP_ORCMB  = 5'd16,
        OP_BSWAP  = 5'd17,
        OP_BCLR   = 5'd18,
        OP_BSET   = 5'd19,
        OP_BFLIP  = 5'd20,
        OP_BGET   = 5'd21
    } bml_op_e;

    typedef struct packed {
        logic  vld;
        word_t data;
    } bml_out_t;

    function automatic word_t rev_bits(input word_t x);
        word_t r;
        for (int i = 0; i < DW; i++) r[i] = x[DW-1-i];
        return r;
    endfunction

    function automatic word_t onehot(input logic [SHW-1:0] idx);
        return word_t'(1) << idx;
    endfunction

endpackage

// File: rtl/bml_count.sv
module bml_count
    import bml_pkg::*;
(
    input  word_t            a,
    output logic [CNTW-1:0]  lzc,
    output logic [CNTW-1:0]  tzc,
    output logic [CNTW-1:0]  pop
);
    // Trailing-zero count via priority scan from the bottom.
    function automatic logic [CNTW-1:0] tz(input word_t x);
        logic [CNTW-1:0] n;
        logic hit;
        n = CNTW'(DW);
        hit = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (!hit && x[i]) begin
                n = CNTW'(i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    word_t a_rev;
    assign a_rev = rev_bits(a);

    always_comb begin
        tzc = tz(a);
        lzc = tz(a_rev);
    end

    // Population count as a tree of per-byte sums.
    logic [3:0] byte_cnt [NBYTE];
    genvar g;
    generate
        for (g = 0; g < NBYTE; g++) begin : g_byte
            always_comb begin
                byte_cnt[g] = '0;
                for (int k = 0; k < 8; k++)
                    byte_cnt[g] = byte_cnt[g] + {3'b0, a[g*8+k]};
            end
        end
    endgenerate

    always_comb begin
        pop = '0;
        for (int j = 0; j < NBYTE; j++) pop = pop + CNTW'(byte_cnt[j]);
    end
endmodule

// File: rtl/bml_rotate.sv
module bml_rotate
    import bml_pkg::*;
(
    input  word_t            a,
    input  logic [SHW-1:0]   amt,
    input  logic             dir_right,
    output word_t            y
);
    // A right rotate by n equals a left rotate by DW-n, which the mask takes modulo DW.
    logic [SHW-1:0] lamt;
    logic [2*DW-1:0] dbl;
    assign lamt = dir_right ? SHW'(0) - amt : amt;
    assign dbl  = {a, a} << lamt;
    assign y    = dbl[2*DW-1:DW];
endmodule

// File: rtl/bml_bytes.sv
module bml_bytes
    import bml_pkg::*;
(
    input  word_t a,
    output word_t orc,
    output word_t swp
);
    genvar g;
    generate
        for (g = 0; g < NBYTE; g++) begin : g_b
            assign orc[g*8 +: 8] = {8{|a[g*8 +: 8]}};
            assign swp[(NBYTE-1-g)*8 +: 8] = a[g*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/bml_unit.sv
module bml_unit
    import bml_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_in,
    input  logic [4:0]  op_in,
    input  logic [31:0] a_in,
    input  logic [31:0] b_in,
    output logic        valid_out,
    output logic [31:0] result
);
    logic [CNTW-1:0] lzc, tzc, pop;
    word_t rot_y, orc_y, swp_y, nxt;
    logic [SHW-1:0] idx;
    logic lt_s, lt_u;
    bml_out_t q;

    assign idx = b_in[SHW-1:0];

    bml_count u_cnt (.a(a_in), .lzc(lzc), .tzc(tzc), .pop(pop));
    bml_rotate u_rot (.a(a_in), .amt(idx), .dir_right(op_in == OP_ROTR), .y(rot_y));
    bml_bytes u_byt (.a(a_in), .orc(orc_y), .swp(swp_y));

    assign lt_s = $signed(a_in) < $signed(b_in);
    assign lt_u = a_in < b_in;

    always_comb begin
        case (op_in)
            OP_ANDINV: nxt = a_in & ~b_in;
            OP_ORINV:  nxt = a_in | ~b_in;
            OP_XNOR:   nxt = ~(a_in ^ b_in);
            OP_LZC:    nxt = DW'(lzc);
            OP_TZC:    nxt = DW'(tzc);
            OP_POP:    nxt = DW'(pop);
            OP_MINS:   nxt = lt_s ? a_in : b_in;
            OP_MAXS:   nxt = lt_s ? b_in : a_in;
            OP_MINU:   nxt = lt_u ? a_in : b_in;
            OP_MAXU:   nxt = lt_u ? b_in : a_in;
            OP_SXB:    nxt = {{(DW-8){a_in[7]}}, a_in[7:0]};
            OP_SXH:    nxt = {{(DW-16){a_in[15]}}, a_in[15:0]};
            OP_ZXB:    nxt = {{(DW-8){1'b0}}, a_in[7:0]};
            OP_ZXH:    nxt = {{(DW-16){1'b0}}, a_in[15:0]};
            OP_ROTL,
            OP_ROTR:   nxt = rot_y;
            OP_ORCMB:  nxt = orc_y;
            OP_BSWAP:  nxt = swp_y;
            OP_BCLR:   nxt = a_in & ~onehot(idx);
            OP_BSET:   nxt = a_in | onehot(idx);
            OP_BFLIP:  nxt = a_in ^ onehot(idx);
            OP_BGET:   nxt = {{(DW-1){1'b0}}, a_in[idx]};
            default:   nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else begin
            q.vld  <= valid_in;
            q.data <= nxt;
        end
    end

    assign valid_out = q.vld;
    assign result    = q.data;

    logic        seen;
    logic [4:0]  op_q;
    word_t       a_q;
    logic [SHW-1:0] idx_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0; op_q <= '0; a_q <= '0; idx_q <= '0;
        end else begin
            seen <= 1'b1; op_q <= op_in; a_q <= a_in; idx_q <= idx;
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (op_in > 5'd21) |=> (result == '0));
    p_rot_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (seen && (op_q == OP_ROTL || op_q == OP_ROTR) && idx_q == '0) |-> (result == a_q));
    p_bget_upper_r10: assert property (@(posedge clk) disable iff (rst)
        (seen && op_q == OP_BGET) |-> (result[DW-1:1] == '0));
endmodule

// File: tb/sim_bml_unit.sv
module sim_bml_unit;
    logic clk = 0, rst = 1, valid_in = 0;
    logic [4:0] op_in = 0;
    logic [31:0] a_in = 0, b_in = 0;
    logic valid_out;
    logic [31:0] result;
    int checks = 0, fails = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    bit done = 0;

    always #5 clk = ~clk;

    bml_unit u0 (.clk(clk), .rst(rst), .valid_in(valid_in), .op_in(op_in),
                 .a_in(a_in), .b_in(b_in), .valid_out(valid_out), .result(result));

    task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] e, input string t);
        @(negedge clk);
        op_in = op; a_in = a; b_in = b; valid_in = 1;
        exp_q.push_back(e); tag_q.push_back(t);
    endtask

    // Monitor: a result issued at negedge n is visible after posedge n+1.
    always @(negedge clk) begin
        if (!rst && valid_out) begin
            logic [31:0] e; string t;
            checks++;
            if (exp_q.size() == 0) begin
                fails++; $display("FAIL R1 unexpected valid_out result=%h expected none", result);
            end else begin
                e = exp_q.pop_front(); t = tag_q.pop_front();
                if (result !== e) begin
                    fails++; $display("FAIL %s actual=%h expected=%h", t, result, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (valid_out !== 0 || result !== 0) begin
            fails++; $display("FAIL R1 reset actual=%b/%h expected=0/0", valid_out, result);
        end
        rst = 0;
        drive(0, 32'hF0F0_FF00, 32'h0FF0_0F0F, 32'hF000_F000, "R2 andinv");
        drive(1, 32'h0000_0001, 32'hFFFF_0000, 32'h0000_FFFF, "R2 orinv");
        drive(2, 32'hAAAA_5555, 32'hAAAA_AAAA, 32'hFFFF_0000, "R2 xnor");
        drive(3, 32'h0000_0000, 32'h0, 32'd32, "R3 lzc zero");
        drive(3, 32'h0001_0000, 32'h0, 32'd15, "R3 lzc");
        drive(4, 32'h0000_0000, 32'h0, 32'd32, "R3 tzc zero");
        drive(4, 32'h8000_0000, 32'h0, 32'd31, "R3 tzc msb");
        drive(5, 32'hFFFF_FFFF, 32'h0, 32'd32, "R4 pop all");
        drive(5, 32'h8421_0F01, 32'h0, 32'd9, "R4 pop");
        drive(6, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFF, "R5 mins");
        drive(7, 32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 maxs");
        drive(8, 32'hFFFF_FFFF, 32'h1, 32'h1, "R5 minu");
        drive(9, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, "R5 maxu");
        drive(10, 32'h1234_5680, 32'h0, 32'hFFFF_FF80, "R6 sxb");
        drive(11, 32'h1234_7FFF, 32'h0, 32'h0000_7FFF, "R6 sxh");
        drive(12, 32'hFFFF_FF80, 32'h0, 32'h0000_0080, "R6 zxb");
        drive(13, 32'hFFFF_8001, 32'h0, 32'h0000_8001, "R6 zxh");
        drive(14, 32'h8000_0001, 32'h0000_0004, 32'h0000_0018, "R7 rotl");
        drive(15, 32'h8000_0001, 32'hFFFF_FFE1, 32'hC000_0000, "R7 rotr mask");
        drive(14, 32'hDEAD_BEEF, 32'h0000_0020, 32'hDEAD_BEEF, "R7 rotl zero");
        drive(15, 32'h1234_5678, 32'h0000_0008, 32'h7812_3456, "R7 rotr");
        drive(16, 32'h0100_8000, 32'h0, 32'hFF00_FF00, "R8 orcomb");
        drive(17, 32'h1122_3344, 32'h0, 32'h4433_2211, "R9 bswap");
        drive(18, 32'hFFFF_FFFF, 32'h0000_003F, 32'h7FFF_FFFF, "R10 bclr");
        drive(19, 32'h0, 32'h0000_0005, 32'h0000_0020, "R10 bset");
        drive(20, 32'h0000_0020, 32'h0000_0025, 32'h0, "R10 binv");
        drive(21, 32'h8000_0000, 32'h0000_001F, 32'h1, "R10 bget");
        drive(21, 32'hFFFF_FFFE, 32'h0, 32'h0, "R10 bget0");
        drive(22, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R11 unused22");
        drive(31, 32'hFFFF_FFFF, 32'h0, 32'h0, "R11 unused31");
        // R12: idle cycle with an operation still updates the result.
        @(negedge clk); valid_in = 0; op_in = 5'd17; a_in = 32'hAABB_CCDD;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (valid_out !== 0 || result !== 32'hDDCC_BBAA) begin
            fails++; $display("FAIL R12 actual=%b/%h expected=0/ddccbbaa", valid_out, result);
        end
        checks++;
        if (exp_q.size() != 0) begin
            fails++; $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule